// File: doc/BRIEF.md
# Strap-configured clock ratio controller

This block is the register bank of a clock and power controller. At reset it copies a 32-bit strap word into a read-only register. It then builds the reset value of its PLL mode register field by field from that word. The block also holds a divider control register, a timer-source control register, an enable mask, a force mask and a fixed identification word. A status word is computed from the enable and force masks.

From the mode and control contents, the block computes the ratios that a clock generator elsewhere applies to each domain. The CPU multiplier is taken relative to the reference clock. The bus divider is taken relative to the CPU. The peripheral-bus and external-bus dividers are taken relative to the bus, and the memory clock follows the bus. The UART divider is taken relative to the CPU. A timer-source select is also output.

The block checks that the reference frequency times the total PLL multiplier falls inside the oscillator's lockable window. If it does not, the block reports no lock and uses the bypass ratio at once. On the next clock edge it also clears the PLL-enable bit of the mode register.

The register interface is a simple one-cycle write port, with a combinational read of the word selected by the same address.

Top module: `clk_ratio_ctrl`

## Requirements
- R1: While `rst_n` is low, the mode register (address 0) is loaded with bit 31 set, then strap[31:30] picks the forward field mode[18:16]. Code 00 clears bit 31 and leaves the field 0. Code 01 writes 5, code 10 writes 4, and code 11 writes 2.
- R2: At reset, mode[23:20] = strap[29:28]+1, mode[27:26] = strap[24:23], mode[11:10] = strap[22:21] and mode[25:24] = strap[18:17]. If strap[27:25] is 2, 4 or 5, the values 0x13, 0x15 or 0x16 are ORed into the mode register; any other code adds nothing. The strap word is readable at address 3.
- R3: Reset values are 0x0000003C for the divider control (address 1) and 0x2B0D8800 for the timer control (address 2). The enable mask (address 5) and the force mask (address 6) reset to zero.
- R4: A write with `wr_en` high stores `wdata` ANDed with a mask: 0xFFF77C3F at address 0, 0x0FFFFFFE at address 1, 0x00800000 at address 2, and 0xBFFC0000 at addresses 5 and 6.
- R5: Writes to the strap (address 3), identification (address 4, reads `ID_VALUE`) and status (address 7) words change nothing.
- R6: The status word reads as the inverse of (enable OR force), ANDed with 0xFFFF0000.
- R7: Let D0 = mode[27:26]+1, FB = ((mode[23:20]−1) mod 16)+1 (so 0 means 16) and FW = 8−mode[18:16]. With lock, `cpu_mult` = D0×FB. Without lock, it is D0.
- R8: Lock holds when mode[31] is set and `IN_FREQ_HZ`×D0×FB×FW lies within [400 MHz, 800 MHz], inclusive. When mode[31] is set without lock and no mode write occurs, mode[31] reads 0 after the next clock edge.
- R9: `bus_div` = D0, `opb_div` = mode[11:10]+1 and `ext_div` = mode[25:24]+2.
- R10: `uart_div` = control0[5:1]+1. `tmr_ref` equals control1[23], where 1 selects the reference clock and 0 selects the CPU clock.
- R11: All ratio outputs and the lock flag reflect a register write at the clock edge that performs it. They are valid in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset; straps sampled while low |
| strap_i | input | 32 | Strap word |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register index for write and read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the word at `addr` |
| cpu_mult_o | output | 7 | CPU clock multiplier over reference |
| bus_div_o | output | 3 | Bus divider from CPU |
| opb_div_o | output | 3 | Peripheral-bus divider from bus |
| ext_div_o | output | 3 | External-bus divider from bus |
| uart_div_o | output | 6 | UART divider from CPU |
| tmr_ref_o | output | 1 | Timer runs from reference clock |
| pll_lock_o | output | 1 | PLL engaged and oscillator in range |

## Verification
The hardest state to reach is the loss of lock with its self-clearing enable bit. It needs the PLL enabled together with a product of three fields that falls just outside the window. It must also be hit from two places: from straps during reset and from a direct mode write. The stimulus resets with a strap word whose product is 3. It writes mode words whose totals are 15, 16, 32 and 33, and one whose feedback field of 0 wraps to 16. It then mixes random writes and random strap resets, so that the self-clear also collides with writes. A behavioural model compares every output on every cycle.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned N_REGS = 1 << ADDR_W;

  typedef enum logic [ADDR_W-1:0] {
    A_MODE  = 3'd0,
    A_CTL0  = 3'd1,
    A_CTL1  = 3'd2,
    A_STRAP = 3'd3,
    A_ID    = 3'd4,
    A_ENA   = 3'd5,
    A_FRC   = 3'd6,
    A_STAT  = 3'd7
  } reg_addr_e;

  localparam logic [REG_W-1:0] MODE_MASK = 32'hFFF7_7C3F;
  localparam logic [REG_W-1:0] CTL0_MASK = 32'h0FFF_FFFE;
  localparam logic [REG_W-1:0] CTL1_MASK = 32'h0080_0000;
  localparam logic [REG_W-1:0] GATE_MASK = 32'hBFFC_0000;
  localparam logic [REG_W-1:0] STAT_MASK = 32'hFFFF_0000;
  localparam logic [REG_W-1:0] CTL0_RST  = 32'h0000_003C;
  localparam logic [REG_W-1:0] CTL1_RST  = 32'h2B0D_8800;

  // Reset image of the mode register, rebuilt from the strap word.
  function automatic logic [REG_W-1:0] strap_to_mode(input logic [REG_W-1:0] s);
    logic [REG_W-1:0] m;
    m = 32'h8000_0000;
    case (s[31:30])
      2'b00:   m[31] = 1'b0;
      2'b01:   m[18:16] = 3'd5;
      2'b10:   m[18:16] = 3'd4;
      default: m[18:16] = 3'd2;
    endcase
    m[23:20] = {2'b00, s[29:28]} + 4'd1;
    case (s[27:25])
      3'd2:    m = m | 32'h13;
      3'd4:    m = m | 32'h15;
      3'd5:    m = m | 32'h16;
      default: m = m;
    endcase
    m[27:26] = s[24:23];
    m[11:10] = s[22:21];
    m[25:24] = s[18:17];
    return m;
  endfunction

  function automatic logic [2:0] d0_ratio(input logic [1:0] f);
    return {1'b0, f} + 3'd1;
  endfunction

  // Feedback field: zero stands for sixteen.
  function automatic logic [4:0] fb_ratio(input logic [3:0] f);
    return (f == 4'd0) ? 5'd16 : {1'b0, f};
  endfunction

  function automatic logic [3:0] fwd_ratio(input logic [2:0] f);
    return 4'd8 - {1'b0, f};
  endfunction
endpackage

// File: rtl/crc_regs.sv
module crc_regs
  import crc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] strap_i,
  input  logic             wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0] wdata,
  input  logic             vco_bad_i,
  output logic [REG_W-1:0] mode_q,
  output logic [REG_W-1:0] ctl0_q,
  output logic [REG_W-1:0] ctl1_q,
  output logic [REG_W-1:0] strap_q,
  output logic [REG_W-1:0] ena_q,
  output logic [REG_W-1:0] frc_q
);
  logic [N_REGS-1:0] wr_sel;
  assign wr_sel = wr_en ? (N_REGS'(1) << addr) : '0;

  logic wr_mode, wr_ctl0, wr_ctl1, wr_ena, wr_frc;
  assign wr_mode = wr_sel[A_MODE];
  assign wr_ctl0 = wr_sel[A_CTL0];
  assign wr_ctl1 = wr_sel[A_CTL1];
  assign wr_ena  = wr_sel[A_ENA];
  assign wr_frc  = wr_sel[A_FRC];

  // Named event: the lock check asks for the enable bit to drop.
  logic auto_clear;
  assign auto_clear = vco_bad_i && !wr_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strap_q <= strap_i;
      mode_q  <= strap_to_mode(strap_i);
      ctl0_q  <= CTL0_RST;
      ctl1_q  <= CTL1_RST;
      ena_q   <= '0;
      frc_q   <= '0;
    end else begin
      if (wr_mode)         mode_q     <= wdata & MODE_MASK;
      else if (auto_clear) mode_q[31] <= 1'b0;
      if (wr_ctl0) ctl0_q <= wdata & CTL0_MASK;
      if (wr_ctl1) ctl1_q <= wdata & CTL1_MASK;
      if (wr_ena)  ena_q  <= wdata & GATE_MASK;
      if (wr_frc)  frc_q  <= wdata & GATE_MASK;
    end
  end

  // R8: an out-of-range oscillator drops the enable bit one edge later
  a_r8_autoclear: assert property (@(posedge clk) disable iff (!rst_n)
    auto_clear |=> !mode_q[31]);

  // R4: the timer control keeps only its writable bit
  a_r4_ctl1_mask: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl1 |=> ((ctl1_q & ~CTL1_MASK) == '0));
endmodule

// File: rtl/crc_ratio.sv
module crc_ratio
  import crc_pkg::*;
#(
  parameter longint unsigned IN_FREQ_HZ = 25_000_000,
  parameter longint unsigned VCO_MIN_HZ = 400_000_000,
  parameter longint unsigned VCO_MAX_HZ = 800_000_000
) (
  input  logic [REG_W-1:0] mode_i,
  input  logic [REG_W-1:0] ctl0_i,
  input  logic [REG_W-1:0] ctl1_i,
  output logic [6:0]       cpu_mult_o,
  output logic [2:0]       bus_div_o,
  output logic [2:0]       opb_div_o,
  output logic [2:0]       ext_div_o,
  output logic [5:0]       uart_div_o,
  output logic             tmr_ref_o,
  output logic             pll_lock_o,
  output logic             vco_bad_o
);
  logic [2:0]  d0;
  logic [4:0]  fb;
  logic [3:0]  fw;
  logic [9:0]  total_m;
  logic [63:0] vco_hz;
  logic        in_range;

  assign d0 = d0_ratio(mode_i[27:26]);
  assign fb = fb_ratio(mode_i[23:20]);
  assign fw = fwd_ratio(mode_i[18:16]);

  assign total_m  = {7'b0, d0} * {5'b0, fb} * {6'b0, fw};
  assign vco_hz   = IN_FREQ_HZ * {54'b0, total_m};
  assign in_range = (vco_hz >= VCO_MIN_HZ) && (vco_hz <= VCO_MAX_HZ);

  assign pll_lock_o = mode_i[31] && in_range;
  assign vco_bad_o  = mode_i[31] && !in_range;

  assign cpu_mult_o = pll_lock_o ? ({4'b0, d0} * {2'b0, fb}) : {4'b0, d0};
  assign bus_div_o  = d0;
  assign opb_div_o  = {1'b0, mode_i[11:10]} + 3'd1;
  assign ext_div_o  = {1'b0, mode_i[25:24]} + 3'd2;
  assign uart_div_o = {1'b0, ctl0_i[5:1]} + 6'd1;
  assign tmr_ref_o  = ctl1_i[23];

  logic unused_bits;
  assign unused_bits = ^{mode_i[30:28], mode_i[19], mode_i[15:12], mode_i[9:0],
                         ctl0_i[31:6], ctl0_i[0], ctl1_i[31:24], ctl1_i[22:0]};
endmodule

// File: rtl/crc_rdmux.sv
module crc_rdmux
  import crc_pkg::*;
#(
  parameter logic [31:0] ID_VALUE = 32'h5C1D_0A17
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  mode_i,
  input  logic [REG_W-1:0]  ctl0_i,
  input  logic [REG_W-1:0]  ctl1_i,
  input  logic [REG_W-1:0]  strap_i,
  input  logic [REG_W-1:0]  ena_i,
  input  logic [REG_W-1:0]  frc_i,
  output logic [REG_W-1:0]  rdata
);
  logic [REG_W-1:0] status_w;
  assign status_w = ~(ena_i | frc_i) & STAT_MASK;

  always_comb begin
    case (reg_addr_e'(addr))
      A_MODE:  rdata = mode_i;
      A_CTL0:  rdata = ctl0_i;
      A_CTL1:  rdata = ctl1_i;
      A_STRAP: rdata = strap_i;
      A_ID:    rdata = ID_VALUE;
      A_ENA:   rdata = ena_i;
      A_FRC:   rdata = frc_i;
      default: rdata = status_w;
    endcase
  end
endmodule

// File: rtl/clk_ratio_ctrl.sv
module clk_ratio_ctrl
  import crc_pkg::*;
#(
  parameter longint unsigned IN_FREQ_HZ = 25_000_000,
  parameter longint unsigned VCO_MIN_HZ = 400_000_000,
  parameter longint unsigned VCO_MAX_HZ = 800_000_000,
  parameter logic [31:0]     ID_VALUE   = 32'h5C1D_0A17
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] strap_i,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [6:0]  cpu_mult_o,
  output logic [2:0]  bus_div_o,
  output logic [2:0]  opb_div_o,
  output logic [2:0]  ext_div_o,
  output logic [5:0]  uart_div_o,
  output logic        tmr_ref_o,
  output logic        pll_lock_o
);
  logic [REG_W-1:0] mode_q, ctl0_q, ctl1_q, strap_q, ena_q, frc_q;
  logic             vco_bad;

  crc_regs i_regs (
    .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .vco_bad_i(vco_bad), .mode_q(mode_q), .ctl0_q(ctl0_q),
    .ctl1_q(ctl1_q), .strap_q(strap_q), .ena_q(ena_q), .frc_q(frc_q)
  );

  crc_ratio #(
    .IN_FREQ_HZ(IN_FREQ_HZ), .VCO_MIN_HZ(VCO_MIN_HZ), .VCO_MAX_HZ(VCO_MAX_HZ)
  ) i_ratio (
    .mode_i(mode_q), .ctl0_i(ctl0_q), .ctl1_i(ctl1_q),
    .cpu_mult_o(cpu_mult_o), .bus_div_o(bus_div_o), .opb_div_o(opb_div_o),
    .ext_div_o(ext_div_o), .uart_div_o(uart_div_o), .tmr_ref_o(tmr_ref_o),
    .pll_lock_o(pll_lock_o), .vco_bad_o(vco_bad)
  );

  crc_rdmux #(.ID_VALUE(ID_VALUE)) i_rdmux (
    .addr(addr), .mode_i(mode_q), .ctl0_i(ctl0_q), .ctl1_i(ctl1_q),
    .strap_i(strap_q), .ena_i(ena_q), .frc_i(frc_q), .rdata(rdata)
  );

  // R7: in bypass the CPU multiplier equals the bus divider
  a_r7_bypass_mult: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_lock_o |-> (cpu_mult_o == {4'b0, bus_div_o}));

  // R7: the CPU multiplier is always a whole multiple of the bus divider
  a_r7_mult_multiple: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_mult_o % {4'b0, bus_div_o}) == 7'd0);

  // R9: the external divider never drops below two
  a_r9_ext_floor: assert property (@(posedge clk) disable iff (!rst_n)
    ext_div_o >= 3'd2);

  // R11: a divider-control write shows on the UART ratio one edge later
  a_r11_uart_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CTL0) |=> (uart_div_o == ({1'b0, $past(wdata[5:1])} + 6'd1)));
endmodule

// File: tb/test_clk_ratio_ctrl.sv
module test_clk_ratio_ctrl;
  localparam longint unsigned FREQ = 25_000_000;
  localparam logic [31:0]     IDV  = 32'h5C1D_0A17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] strap_i = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [6:0]  cpu_mult_o;
  logic [2:0]  bus_div_o, opb_div_o, ext_div_o;
  logic [5:0]  uart_div_o;
  logic        tmr_ref_o, pll_lock_o;

  always #10 clk = ~clk;

  clk_ratio_ctrl #(.IN_FREQ_HZ(FREQ), .ID_VALUE(IDV)) i_clk_ratio_ctrl (
    .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cpu_mult_o(cpu_mult_o), .bus_div_o(bus_div_o),
    .opb_div_o(opb_div_o), .ext_div_o(ext_div_o), .uart_div_o(uart_div_o),
    .tmr_ref_o(tmr_ref_o), .pll_lock_o(pll_lock_o)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // Reference model state
  bit [31:0] r_mode, r_c0, r_c1, r_strap, r_ena, r_frc;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit [31:0] m_from_strap(input bit [31:0] s);
    int pf, code, pt;
    bit [31:0] m;
    pf = int'((s >> 30) & 3);
    code = (pf == 1) ? 5 : (pf == 2) ? 4 : (pf == 3) ? 2 : 0;
    m = (pf == 0) ? 32'h0 : 32'h8000_0000;
    m |= 32'(code) << 16;
    m |= 32'(((s >> 28) & 3) + 1) << 20;
    pt = int'((s >> 25) & 7);
    if (pt == 2) m |= 32'h13;
    if (pt == 4) m |= 32'h15;
    if (pt == 5) m |= 32'h16;
    m |= ((s >> 23) & 3) << 26;
    m |= ((s >> 21) & 3) << 10;
    m |= ((s >> 17) & 3) << 24;
    return m;
  endfunction

  function automatic int e_d0();  return int'((r_mode >> 26) & 3) + 1; endfunction
  function automatic int e_fb();  return ((int'(r_mode >> 20) - 1) & 15) + 1; endfunction
  function automatic int e_fw();  return 8 - int'((r_mode >> 16) & 7); endfunction
  function automatic bit e_lock();
    longint v;
    v = longint'(FREQ) * e_d0() * e_fb() * e_fw();
    return r_mode[31] && v >= 400_000_000 && v <= 800_000_000;
  endfunction
  function automatic int e_cpu(); return e_lock() ? e_d0() * e_fb() : e_d0(); endfunction

  function automatic bit [31:0] e_read(input int a);
    case (a)
      0: return r_mode;
      1: return r_c0;
      2: return r_c1;
      3: return r_strap;
      4: return IDV;
      5: return r_ena;
      6: return r_frc;
      default: return (~(r_ena | r_frc)) & 32'hFFFF_0000;
    endcase
  endfunction

  task automatic model_edge(input bit r, input bit w, input int a, input bit [31:0] d);
    bit clr;
    clr = r_mode[31] && !e_lock();
    if (!r) begin
      r_strap = strap_i; r_mode = m_from_strap(strap_i);
      r_c0 = 32'h3C; r_c1 = 32'h2B0D_8800; r_ena = 0; r_frc = 0;
    end else begin
      if (w && a == 0) r_mode = d & 32'hFFF7_7C3F;
      else if (clr) r_mode[31] = 1'b0;
      if (w && a == 1) r_c0 = d & 32'h0FFF_FFFE;
      if (w && a == 2) r_c1 = d & 32'h0080_0000;
      if (w && (a == 5)) r_ena = d & 32'hBFFC_0000;
      if (w && (a == 6)) r_frc = d & 32'hBFFC_0000;
    end
  endtask

  task automatic compare_all();
    chk("R4 R5 R6 readback", rdata, e_read(int'(addr)));
    chk("R7 cpu_mult", cpu_mult_o, e_cpu());
    chk("R8 lock", pll_lock_o, e_lock());
    chk("R9 bus_div", bus_div_o, e_d0());
    chk("R9 opb_div", opb_div_o, ((r_mode >> 10) & 3) + 1);
    chk("R9 ext_div", ext_div_o, ((r_mode >> 24) & 3) + 2);
    chk("R10 uart_div", uart_div_o, ((r_c0 >> 1) & 31) + 1);
    chk("R10 tmr_ref", tmr_ref_o, r_c1[23]);
  endtask

  // One cycle: drive at negedge, model the edge, compare at next negedge.
  task automatic cyc(input bit r, input bit w, input int a, input bit [31:0] d);
    rst_n = r; wr_en = w; addr = 3'(a); wdata = d;
    @(posedge clk);
    model_edge(r, w, a, d);
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset(input bit [31:0] s);
    strap_i = s;
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 0, 0);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R1 R2: strap word giving total multiplier 16 at 25 MHz
    do_reset(32'h9AA4_0000);
    chk("R1 mode after strap reset", rdata, 32'h8624_0416);
    chk("R7 locked cpu_mult", cpu_mult_o, 4);
    chk("R8 locked", pll_lock_o, 1);
    cyc(1'b1, 1'b0, 0, 0);
    chk("R1 mode held", rdata, 32'h8624_0416);
    cyc(1'b1, 1'b0, 1, 0); chk("R3 ctl0 reset", rdata, 32'h3C);
    chk("R10 uart reset", uart_div_o, 31);
    cyc(1'b1, 1'b0, 2, 0); chk("R3 ctl1 reset", rdata, 32'h2B0D_8800);
    chk("R10 timer from cpu", tmr_ref_o, 0);
    cyc(1'b1, 1'b0, 5, 0); chk("R3 enable reset", rdata, 0);
    cyc(1'b1, 1'b0, 6, 0); chk("R3 force reset", rdata, 0);
    cyc(1'b1, 1'b0, 7, 0); chk("R6 status reset", rdata, 32'hFFFF_0000);
    cyc(1'b1, 1'b0, 3, 0); chk("R2 strap readback", rdata, 32'h9AA4_0000);

    // R8: strap reset with product 3 -> bit 31 drops after first edge
    do_reset(32'h4000_0000);
    chk("R8 no lock during reset", pll_lock_o, 0);
    chk("R1 forward code 01", rdata, 32'h8015_0000);
    cyc(1'b1, 1'b0, 0, 0);
    chk("R8 enable self-cleared", rdata, 32'h0015_0000);

    // R1: bypass code, R2: other trim codes
    do_reset(32'h0000_0000);
    chk("R1 bypass strap", rdata, 32'h0010_0000);
    chk("R7 bypass cpu_mult", cpu_mult_o, 1);
    do_reset(32'hC400_0000);
    do_reset(32'h4800_0000);
    do_reset(32'h3B66_0000);
    cyc(1'b1, 1'b0, 0, 0);

    // R4 R5: all-ones to every address
    for (int a = 0; a < 8; a++) begin
      cyc(1'b1, 1'b1, a, 32'hFFFF_FFFF);
      cyc(1'b1, 1'b0, a, 0);
    end
    cyc(1'b1, 1'b0, 2, 0); chk("R4 ctl1 mask", rdata, 32'h0080_0000);
    chk("R10 timer from reference", tmr_ref_o, 1);
    cyc(1'b1, 1'b0, 3, 0); chk("R5 strap unchanged", rdata, 32'h3B66_0000);
    cyc(1'b1, 1'b0, 4, 0); chk("R5 id unchanged", rdata, IDV);
    cyc(1'b1, 1'b0, 7, 0); chk("R6 status all masked", rdata, 32'h4003_0000);

    // R7 R8: window edges
    cyc(1'b1, 1'b1, 0, 32'h8444_0000);
    chk("R8 800MHz locks", pll_lock_o, 1); chk("R7 cpu 8", cpu_mult_o, 8);
    cyc(1'b1, 1'b1, 0, 32'h80B5_0000);
    chk("R8 825MHz no lock", pll_lock_o, 0); chk("R7 bypass 1", cpu_mult_o, 1);
    cyc(1'b1, 1'b0, 0, 0); chk("R8 bit31 cleared", rdata, 32'h00B5_0000);
    cyc(1'b1, 1'b1, 0, 32'h8055_0000);
    chk("R8 375MHz no lock", pll_lock_o, 0);
    cyc(1'b1, 1'b1, 0, 32'h8020_0000);
    chk("R8 400MHz locks", pll_lock_o, 1); chk("R7 cpu 2", cpu_mult_o, 2);
    cyc(1'b1, 1'b1, 0, 32'h8007_0000);
    chk("R7 feedback zero is 16", cpu_mult_o, 16);

    // R11: divider write visible the cycle after
    cyc(1'b1, 1'b1, 1, 32'h0000_003E);
    chk("R11 uart after write", uart_div_o, 32);
    cyc(1'b1, 1'b1, 5, 32'h0001_0000);
    cyc(1'b1, 1'b1, 6, 32'h8000_0000);
    cyc(1'b1, 1'b0, 7, 0); chk("R6 status mix", rdata, 32'h7FFF_0000);

    // Random mix with occasional strap resets
    for (int k = 0; k < 600; k++) begin
      bit r;
      r = ($urandom % 40) != 0;
      if (!r) strap_i = $urandom;
      cyc(r, bit'($urandom % 2), int'($urandom % 8), $urandom);
    end
    finish_run();
  end
endmodule